// File: doc/BRIEF.md
# Polarity-Selectable Edge-Capture Interrupt Unit

This block watches 24 pad inputs, arranged as three ports of eight lines, for edges and raises an interrupt when one arrives. Each line has its own polarity bit, which picks rising or falling edges, and its own enable bit. A qualifying edge on an enabled line is latched into a per-port capture register. A 3-bit pending summary flags every port whose capture register is nonzero, and a single active-high interrupt is the OR of those three flags.

Software reaches the polarity, enable and capture registers through a narrow register port: a port index, a register kind, write data, a write strobe and combinational read data. To service an interrupt, software reads a capture register and writes it back. Each bit written as 0 is cleared and each bit written as 1 is kept. Pad inputs are resynchronised by two flops and compared with the value they had one cycle earlier.

A small arming state machine keeps edge detection off until the synchronizer and its history register hold real pad values after reset. Without it, the reset contents of those flops could appear as a false edge. From reset the machine passes through ARM_FILL_A, ARM_FILL_B and ARM_FILL_C, one state per clock, and then stays in ARM_RUN. Detection is enabled only while the machine is in ARM_RUN.

Top module: `edgecap_top`

## Requirements
- R1: While reset is held, and after reset is released, all polarity, enable and capture registers read 0. In that state `pending` is 0 and `irq` is low.
- R2: A write with `reg_kind`=0 (polarity) or `reg_kind`=1 (enable) and `reg_idx` 0 to 2 loads `reg_wdata` into that port's register. The new value reads back from the next cycle.
- R3: A line with its enable bit set and its polarity bit at 1 captures a 0-to-1 change. If the pad changes before clock edge k, the capture bit reads 1 after clock edge k+2.
- R4: A line with its polarity bit at 0 captures only 1-to-0 changes. The edge opposite to the selected polarity captures nothing.
- R5: A line whose enable bit is clear never sets its capture bit.
- R6: `pending[p]` is 1 exactly when the capture register of port p is nonzero. `irq` is high exactly when `pending` is nonzero.
- R7: A write with `reg_kind`=2 (capture) clears every capture bit of that port that is written as 0 and keeps every bit that is written as 1.
- R8: If an edge sets a bit in the same cycle that a capture write clears it, the bit stays set.
- R9: No edge is detected at the first three clock edges after reset is released. A pad that is already high at reset does not register as a rising edge.
- R10: Reads with `reg_kind`=3, or with `reg_idx`=3, return 0. Writes with either of those values change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 24 | Pad inputs; line 8*p+b is bit b of port p |
| reg_idx | input | 2 | Port index of the register access (0 to 2) |
| reg_kind | input | 2 | Register kind: 0 polarity, 1 enable, 2 capture, 3 reserved |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data of the addressed register |
| pending | output | 3 | Per-port capture-nonzero summary |
| irq | output | 1 | Active-high interrupt level |

## Verification
The assertions check four things on every cycle:
- A pending flag falls only right after a capture write to its own port.
- A pending flag rises only after a cycle with detection armed and at least one enable bit set in that port.
- Polarity and enable writes land in the addressed port.
- Nothing is pending when reset is released.

Other behaviours are shown only by the bench's scenarios:
- the per-line polarity choice
- the two-cycle capture latency
- the masked write-back
- the set-wins collision between an edge and a clearing write
- the reserved kind and index
- the warm-up that hides a pad held high through reset

A behavioural reference model, compared on every clock, covers the read data and the interrupt outputs across all of these scenarios.

// File: rtl/edgecap_pkg.sv
package edgecap_pkg;

    typedef enum logic [1:0] {
        KIND_POL  = 2'd0,
        KIND_ENAB = 2'd1,
        KIND_ID   = 2'd2,
        KIND_RSVD = 2'd3
    } reg_kind_e;

    typedef enum logic [1:0] {
        ARM_FILL_A,
        ARM_FILL_B,
        ARM_FILL_C,
        ARM_RUN
    } arm_state_e;

endpackage

// File: rtl/edgecap_sync.sv
module edgecap_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [W-1:0] hist_q;

    // two-flop resynchroniser followed by a one-cycle history register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
            hist_q   <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
            hist_q   <= stage2_q;
        end
    end

    assign cur  = stage2_q;
    assign prev = hist_q;
endmodule

// File: rtl/edgecap_arm_fsm.sv
module edgecap_arm_fsm
    import edgecap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic armed
);
    arm_state_e state_q;
    arm_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARM_FILL_A;
        else        state_q <= state_d;
    end

    // next-state: one fill state per synchronizer/history stage
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_FILL_A: state_d = ARM_FILL_B;
            ARM_FILL_B: state_d = ARM_FILL_C;
            ARM_FILL_C: state_d = ARM_RUN;
            ARM_RUN:    state_d = ARM_RUN;
        endcase
    end

    // outputs
    always_comb begin
        armed = 1'b0;
        unique case (state_q)
            ARM_FILL_A, ARM_FILL_B, ARM_FILL_C: armed = 1'b0;
            ARM_RUN:                            armed = 1'b1;
        endcase
    end
endmodule

// File: rtl/edgecap_port.sv
module edgecap_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         armed,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic         wr_pol,
    input  logic         wr_en,
    input  logic         wr_id,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] en_q,
    output logic [W-1:0] id_q,
    output logic         pend
);
    logic [W-1:0] rise;
    logic [W-1:0] fall;
    logic [W-1:0] hit;
    logic [W-1:0] id_d;

    assign rise = cur & ~prev;
    assign fall = ~cur & prev;
    assign hit  = en_q & ((pol_q & rise) | (~pol_q & fall)) & {W{armed}};

    // masked write-back clears zeros; a fresh hit always wins
    always_comb begin
        if (wr_id) id_d = (id_q & wdata) | hit;
        else       id_d = id_q | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q <= '0;
            en_q  <= '0;
            id_q  <= '0;
        end else begin
            if (wr_pol) pol_q <= wdata;
            if (wr_en)  en_q  <= wdata;
            id_q <= id_d;
        end
    end

    assign pend = |id_q;
endmodule

// File: rtl/edgecap_top.sv
module edgecap_top
    import edgecap_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 8,
    parameter int IDX_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
    input  logic [IDX_W-1:0]            reg_idx,
    input  logic [1:0]                  reg_kind,
    input  logic [PORT_W-1:0]           reg_wdata,
    input  logic                        reg_we,
    output logic [PORT_W-1:0]           reg_rdata,
    output logic [NUM_PORTS-1:0]        pending,
    output logic                        irq
);
    localparam int LINES = NUM_PORTS * PORT_W;

    reg_kind_e kind;
    logic      armed;
    logic [LINES-1:0] sync_cur;
    logic [LINES-1:0] sync_prev;
    logic [NUM_PORTS-1:0][PORT_W-1:0] pol_w;
    logic [NUM_PORTS-1:0][PORT_W-1:0] en_w;
    logic [NUM_PORTS-1:0][PORT_W-1:0] id_w;

    assign kind = reg_kind_e'(reg_kind);

    edgecap_sync #(.W(LINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .cur  (sync_cur),
        .prev (sync_prev)
    );

    edgecap_arm_fsm u_arm (
        .clk  (clk),
        .rst_n(rst_n),
        .armed(armed)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic sel;
        assign sel = reg_we && (reg_idx == IDX_W'(p));

        edgecap_port #(.W(PORT_W)) u_port (
            .clk   (clk),
            .rst_n (rst_n),
            .armed (armed),
            .cur   (sync_cur[p*PORT_W +: PORT_W]),
            .prev  (sync_prev[p*PORT_W +: PORT_W]),
            .wr_pol(sel && (kind == KIND_POL)),
            .wr_en (sel && (kind == KIND_ENAB)),
            .wr_id (sel && (kind == KIND_ID)),
            .wdata (reg_wdata),
            .pol_q (pol_w[p]),
            .en_q  (en_w[p]),
            .id_q  (id_w[p]),
            .pend  (pending[p])
        );
    end

    // read mux: unmatched index or reserved kind reads zero
    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (reg_idx == IDX_W'(p)) begin
                unique case (kind)
                    KIND_POL:  reg_rdata = pol_w[p];
                    KIND_ENAB: reg_rdata = en_w[p];
                    KIND_ID:   reg_rdata = id_w[p];
                    KIND_RSVD: reg_rdata = '0;
                endcase
            end
        end
    end

    assign irq = |pending;
endmodule

// File: rtl/edgecap_checker.sv
module edgecap_checker
    import edgecap_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 8,
    parameter int IDX_W     = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [IDX_W-1:0]                 reg_idx,
    input logic [1:0]                       reg_kind,
    input logic [PORT_W-1:0]                reg_wdata,
    input logic                             reg_we,
    input logic [NUM_PORTS-1:0]             pending,
    input logic                             irq,
    input logic                             armed,
    input logic [NUM_PORTS-1:0][PORT_W-1:0] pol_w,
    input logic [NUM_PORTS-1:0][PORT_W-1:0] en_w
);
    // R1: nothing is pending right after reset release
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (pending == '0 && !irq));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        // R7: a pending flag drops only after a capture write to its port
        assert_clear_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pending[p]) |-> $past(reg_we && reg_kind == KIND_ID && reg_idx == IDX_W'(p)));

        // R5: a pending flag rises only when the port had some enable set
        assert_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pending[p]) |-> $past(en_w[p] != '0));

        // R9: no capture before the warm-up has finished
        assert_armed_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pending[p]) |-> $past(armed));

        // R2: polarity writes land in the addressed port
        assert_pol_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_kind == KIND_POL && reg_idx == IDX_W'(p)) |=> (pol_w[p] == $past(reg_wdata)));

        // R2: enable writes land in the addressed port
        assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_kind == KIND_ENAB && reg_idx == IDX_W'(p)) |=> (en_w[p] == $past(reg_wdata)));
    end
endmodule

bind edgecap_top edgecap_checker #(
    .NUM_PORTS(NUM_PORTS),
    .PORT_W   (PORT_W),
    .IDX_W    (IDX_W)
) u_edgecap_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_idx  (reg_idx),
    .reg_kind (reg_kind),
    .reg_wdata(reg_wdata),
    .reg_we   (reg_we),
    .pending  (pending),
    .irq      (irq),
    .armed    (armed),
    .pol_w    (pol_w),
    .en_w     (en_w)
);

// File: tb/edgecap_top_bench.sv
`timescale 1ns/1ps
module edgecap_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pad_in = '0;
    logic [1:0]  reg_idx = '0;
    logic [1:0]  reg_kind = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_rdata;
    logic [2:0]  pending;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    edgecap_top u_edgecap_top (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .reg_idx(reg_idx),
        .reg_kind(reg_kind), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .pending(pending), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [23:0] m_pol, m_en, m_id, m_s1, m_s2, m_prev, m_hit;
    int          m_age;
    bit          m_ok = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pol = '0; m_en = '0; m_id = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0;
            m_age = 0; m_ok = 1'b1;
        end else begin
            m_hit = '0;
            if (m_age >= 3) begin
                for (int i = 0; i < 24; i++) begin
                    if (m_en[i] && (m_pol[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i])))
                        m_hit[i] = 1'b1;
                end
            end
            if (reg_we && reg_idx < 2'd3) begin
                case (reg_kind)
                    2'd0: m_pol[reg_idx*8 +: 8] = reg_wdata;
                    2'd1: m_en[reg_idx*8 +: 8]  = reg_wdata;
                    2'd2: m_id[reg_idx*8 +: 8]  = m_id[reg_idx*8 +: 8] & reg_wdata;
                    default: ;
                endcase
            end
            m_id   = m_id | m_hit;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pad_in;
            if (m_age < 3) m_age++;
        end
    end

    function automatic logic [7:0] model_rdata();
        if (reg_idx == 2'd3) return 8'h00;
        case (reg_kind)
            2'd0: return m_pol[reg_idx*8 +: 8];
            2'd1: return m_en[reg_idx*8 +: 8];
            2'd2: return m_id[reg_idx*8 +: 8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [2:0] model_pend();
        return {|m_id[23:16], |m_id[15:8], |m_id[7:0]};
    endfunction

    // every-clock comparison against the model (R2, R6)
    always @(negedge clk) begin
        if (rst_n && m_ok) begin
            checks++;
            if (reg_rdata !== model_rdata()) begin
                errors++;
                $display("FAIL R2 model rdata: actual %h expected %h", reg_rdata, model_rdata());
            end
            checks++;
            if (pending !== model_pend() || irq !== (|model_pend())) begin
                errors++;
                $display("FAIL R6 model pending/irq: actual %b/%b expected %b/%b",
                         pending, irq, model_pend(), |model_pend());
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [1:0] kind, input logic [1:0] idx, input logic [7:0] data);
        reg_kind = kind; reg_idx = idx; reg_wdata = data; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] kind, input logic [1:0] idx, input logic [7:0] exp);
        reg_kind = kind; reg_idx = idx;
        #2;
        chk(req, reg_rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic chk_pend(input string req, input logic [2:0] exp);
        chk(req, {5'd0, pending}, {5'd0, exp});
        chk(req, {7'd0, irq}, {7'd0, |exp});
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(8 * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: everything clear after reset
        for (int p = 0; p < 3; p++) begin
            rd("R1 pol reset", 2'd0, 2'(p), 8'h00);
            rd("R1 en reset",  2'd1, 2'(p), 8'h00);
            rd("R1 id reset",  2'd2, 2'(p), 8'h00);
        end
        chk_pend("R1 pending reset", 3'b000);

        // R2: configuration writes and read-back
        wr(2'd0, 2'd0, 8'hFF);
        wr(2'd1, 2'd0, 8'h0F);
        wr(2'd0, 2'd1, 8'h00);
        wr(2'd1, 2'd1, 8'hFF);
        rd("R2 pol0", 2'd0, 2'd0, 8'hFF);
        rd("R2 en0",  2'd1, 2'd0, 8'h0F);
        rd("R2 en1",  2'd1, 2'd1, 8'hFF);

        // R3: rising edge, two-cycle latency
        pad_in[0] = 1'b1;
        idle(2);
        chk("R3 not yet captured", {7'd0, pending[0]}, 8'h00);
        idle(1);
        rd("R3 rising captured", 2'd2, 2'd0, 8'h01);
        chk_pend("R6 port0 pending", 3'b001);

        // R4: opposite edge ignored
        pad_in[0] = 1'b0;
        idle(3);
        rd("R4 falling ignored with rising pol", 2'd2, 2'd0, 8'h01);

        // R5: disabled line
        pad_in[4] = 1'b1; idle(3);
        pad_in[4] = 1'b0; idle(3);
        rd("R5 disabled line", 2'd2, 2'd0, 8'h01);

        // R4: falling polarity on port 1
        pad_in[8] = 1'b1; idle(3);
        rd("R4 rising ignored with falling pol", 2'd2, 2'd1, 8'h00);
        pad_in[8] = 1'b0; idle(3);
        rd("R4 falling captured", 2'd2, 2'd1, 8'h01);
        chk_pend("R6 two ports pending", 3'b011);

        // R7: masked write-back
        pad_in[1] = 1'b1; idle(3);
        rd("R7 two bits set", 2'd2, 2'd0, 8'h03);
        wr(2'd2, 2'd0, 8'hFE);
        rd("R7 bit0 cleared bit1 kept", 2'd2, 2'd0, 8'h02);
        wr(2'd2, 2'd1, 8'h00);
        chk_pend("R7 port1 cleared", 3'b001);
        wr(2'd2, 2'd0, 8'h00);
        chk_pend("R6 all clear", 3'b000);

        // R8: edge and clearing write in the same cycle
        pad_in[2] = 1'b1;
        idle(2);
        reg_kind = 2'd2; reg_idx = 2'd0; reg_wdata = 8'h00; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
        rd("R8 set wins over clear", 2'd2, 2'd0, 8'h04);
        wr(2'd2, 2'd0, 8'h00);
        rd("R8 later clear works", 2'd2, 2'd0, 8'h00);

        // R10: reserved kind and index
        rd("R10 reserved kind reads 0", 2'd3, 2'd0, 8'h00);
        rd("R10 index 3 reads 0", 2'd0, 2'd3, 8'h00);
        wr(2'd0, 2'd3, 8'hAA);
        wr(2'd3, 2'd0, 8'h55);
        rd("R10 pol0 untouched", 2'd0, 2'd0, 8'hFF);
        rd("R10 pol1 untouched", 2'd0, 2'd1, 8'h00);
        rd("R10 en0 untouched", 2'd1, 2'd0, 8'h0F);

        // R9: pad high through reset is not an edge
        pad_in[23:16] = 8'hFF;
        idle(3);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        wr(2'd0, 2'd2, 8'hFF);
        wr(2'd1, 2'd2, 8'hFF);
        idle(4);
        rd("R9 no false edge after reset", 2'd2, 2'd2, 8'h00);
        chk_pend("R9 nothing pending", 3'b000);
        pad_in[23] = 1'b0; idle(3);
        pad_in[23] = 1'b1; idle(3);
        rd("R9 detection active after warm-up", 2'd2, 2'd2, 8'h80);
        chk_pend("R6 port2 pending", 3'b100);

        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule